// File: doc/BRIEF.md
# Single-Cycle Add-Immediate Core

This block is a minimal single-cycle processor that runs exactly one instruction: the I-type add-immediate. It holds a program counter and presents it as the instruction address. It takes the 32-bit instruction word back in the same cycle and decodes the source register, the destination register and the 12-bit immediate. It sign-extends the immediate and adds it to the source register value. At the next rising clock edge it writes the sum into the destination register, and the program counter moves on by four.

The datapath is wired for this one instruction only:
- The arithmetic unit is held on its add operation.
- The second operand is always the immediate.
- Register write is always on.

The memory-side outputs exist only to keep the shape of a fuller core. They are driven to zero, with an all-zero byte write mask, so no store can ever happen.

Eight architectural registers are brought out as debug ports so that a bench can follow execution: x1, x2 and x5 through x10. The register file is internal.

Top module: `addi_core`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `pcOut` is 0 and every register reads 0.
- R2: On every clock edge with `rstN` high, `pcOut` increases by 4, modulo 2^32.
- R3: The source register index is taken from `instrWord[19:15]` and the destination index from `instrWord[11:7]`.
- R4: The immediate is `instrWord[31:20]` sign-extended to 32 bits, so a word with bit 31 set adds a negative value.
- R5: At each clock edge the destination register receives the source register value plus the immediate, modulo 2^32.
- R6: A write whose destination index is 0 is discarded, and register x0 always reads as 0 when used as a source.
- R7: Every register other than the destination keeps its value across the edge. This includes registers x11 to x31, which have no debug port.
- R8: `instrWord[14:12]` and `instrWord[6:0]` have no effect: any values there still produce an add of the immediate.
- R9: `memAddr` and `memWrData` are always 0, and `memWrMask` is always 4'b0000.
- R10: The debug ports show the registers in this order: `dbgX1`=x1, `dbgX2`=x2, `dbgX5`..`dbgX10`=x5..x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| instrWord | input | 32 | Instruction fetched from address `pcOut` |
| pcOut | output | 32 | Program counter, used as instruction address |
| memAddr | output | 32 | Data memory address, held at 0 |
| memWrData | output | 32 | Data memory write data, held at 0 |
| memWrMask | output | 4 | Byte write mask, held at 0 |
| dbgX1 | output | 32 | Register x1 |
| dbgX2 | output | 32 | Register x2 |
| dbgX5 | output | 32 | Register x5 |
| dbgX6 | output | 32 | Register x6 |
| dbgX7 | output | 32 | Register x7 |
| dbgX8 | output | 32 | Register x8 |
| dbgX9 | output | 32 | Register x9 |
| dbgX10 | output | 32 | Register x10 |

## Verification
The assertions check on every cycle that:
- the program counter steps by four;
- the memory outputs stay at zero;
- a word that targets x1 from x0 leaves x1 holding the sign-extended immediate;
- x1 is left untouched when another register is the target.

Only the bench's scenarios can show the rest:
- correct sign extension of immediates at both range limits;
- wrap-around of the sum;
- that writes to x0 are discarded;
- that hidden registers hold their values;
- that the funct3 and opcode bits are ignored.

The bench shows these by checking the debug registers against a software register model after every instruction.

// File: rtl/addi_core_pkg.sv
package addi_core_pkg;
  localparam int XLEN = 32;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_PASS = 4'd15
  } aluSel_e;

  typedef struct packed {
    logic    regWrite;
    aluSel_e aluSel;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [11:0] imm;
    logic [4:0]  rs1;
    logic [4:0]  rd;
  } instrFields_t;
endpackage

// File: rtl/addi_core_ctrl.sv
module addi_core_ctrl
  import addi_core_pkg::*;
(
  output ctrlStrobes_t strobes
);
  // Hard-wired for the single supported instruction.
  always_comb begin
    strobes.regWrite = 1'b1;
    strobes.aluSel   = ALU_ADD;
  end
endmodule

// File: rtl/addi_core_regfile.sv
module addi_core_regfile #(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  parameter int DBG_N     = 8,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [IDX_W-1:0]              rdIdx,
  input  logic [IDX_W-1:0]              wrIdx,
  input  logic                          wrEn,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [DBG_N-1:0][DATA_W-1:0]  dbgOut
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  // Debug slot k maps to x1, x2, x5, x6, ... x10.
  function automatic int dbgIndex(input int k);
    return (k < 2) ? k + 1 : k + 3;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn && (wrIdx != '0)) begin
      regs[wrIdx] <= wrData;
    end
  end

  assign rdData = (rdIdx == '0) ? '0 : regs[rdIdx];

  for (genvar k = 0; k < DBG_N; k++) begin : g_dbg
    assign dbgOut[k] = regs[dbgIndex(k)];
  end
endmodule

// File: rtl/addi_core_datapath.sv
module addi_core_datapath
  import addi_core_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_COUNT = 32,
  parameter int DBG_N     = 8,
  parameter int PC_STEP   = 4,
  parameter int IMM_W     = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DATA_W-1:0]             instrWord,
  input  ctrlStrobes_t                  strobes,
  output logic [DATA_W-1:0]             pcOut,
  output logic [DBG_N-1:0][DATA_W-1:0]  dbgRegs
);
  localparam int IDX_W = $clog2(REG_COUNT);

  logic [DATA_W-1:0] pcReg;
  instrFields_t      fields;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] srcVal;
  logic [DATA_W-1:0] aluOut;

  // Program counter.
  always_ff @(posedge clk) begin
    if (!rstN) pcReg <= '0;
    else       pcReg <= pcReg + DATA_W'(PC_STEP);
  end
  assign pcOut = pcReg;

  // Field decode.
  assign fields.imm = instrWord[31:20];
  assign fields.rs1 = instrWord[19:15];
  assign fields.rd  = instrWord[11:7];

  // Immediate generator: sign extension.
  assign immExt = {{(DATA_W-IMM_W){fields.imm[IMM_W-1]}}, fields.imm};

  // Arithmetic unit, operand B is always the immediate.
  always_comb begin
    unique case (strobes.aluSel)
      ALU_ADD:  aluOut = srcVal + immExt;
      default:  aluOut = immExt;
    endcase
  end

  addi_core_regfile #(
    .DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .DBG_N(DBG_N)
  ) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .rdIdx  (IDX_W'(fields.rs1)),
    .wrIdx  (IDX_W'(fields.rd)),
    .wrEn   (strobes.regWrite),
    .wrData (aluOut),
    .rdData (srcVal),
    .dbgOut (dbgRegs)
  );
endmodule

// File: rtl/addi_core.sv
module addi_core
  import addi_core_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instrWord,
  output logic [31:0] pcOut,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  output logic [3:0]  memWrMask,
  output logic [31:0] dbgX1,
  output logic [31:0] dbgX2,
  output logic [31:0] dbgX5,
  output logic [31:0] dbgX6,
  output logic [31:0] dbgX7,
  output logic [31:0] dbgX8,
  output logic [31:0] dbgX9,
  output logic [31:0] dbgX10
);
  ctrlStrobes_t strobes;
  logic [7:0][31:0] dbgRegs;

  addi_core_ctrl u_ctrl (.strobes(strobes));

  addi_core_datapath #(
    .DATA_W(32), .REG_COUNT(32), .DBG_N(8), .PC_STEP(4), .IMM_W(12)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .strobes   (strobes),
    .pcOut     (pcOut),
    .dbgRegs   (dbgRegs)
  );

  // No memory access for this instruction.
  assign memAddr   = '0;
  assign memWrData = '0;
  assign memWrMask = '0;

  assign dbgX1  = dbgRegs[0];
  assign dbgX2  = dbgRegs[1];
  assign dbgX5  = dbgRegs[2];
  assign dbgX6  = dbgRegs[3];
  assign dbgX7  = dbgRegs[4];
  assign dbgX8  = dbgRegs[5];
  assign dbgX9  = dbgRegs[6];
  assign dbgX10 = dbgRegs[7];
endmodule

// File: rtl/addi_core_chk.sv
module addi_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instrWord,
  input logic [31:0] pcOut,
  input logic [31:0] memAddr,
  input logic [31:0] memWrData,
  input logic [3:0]  memWrMask,
  input logic [31:0] dbgX1
);
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> pcOut == $past(pcOut) + 32'd4); // R2

  AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    memWrMask == 4'b0000 && memAddr == 32'd0 && memWrData == 32'd0); // R9

  AST_X1_FROM_X0: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[11:7] == 5'd1 && instrWord[19:15] == 5'd0)
      |=> dbgX1 == {{20{$past(instrWord[31])}}, $past(instrWord[31:20])}); // R4

  AST_X1_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[11:7] != 5'd1) |=> $stable(dbgX1)); // R7

  AST_RESET_PC: assert property (@(posedge clk)
    !$past(rstN) |-> pcOut == 32'd0); // R1
endmodule

bind addi_core addi_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrWord (instrWord),
  .pcOut     (pcOut),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .memWrMask (memWrMask),
  .dbgX1     (dbgX1)
);

// File: tb/addi_core_test.sv
module addi_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrWord = 32'd0;
  logic [31:0] pcOut, memAddr, memWrData;
  logic [3:0]  memWrMask;
  logic [31:0] dbgX1, dbgX2, dbgX5, dbgX6, dbgX7, dbgX8, dbgX9, dbgX10;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];
  logic [31:0] expPc;

  always #10 clk = ~clk;

  addi_core uut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcOut(pcOut),
    .memAddr(memAddr), .memWrData(memWrData), .memWrMask(memWrMask),
    .dbgX1(dbgX1), .dbgX2(dbgX2), .dbgX5(dbgX5), .dbgX6(dbgX6),
    .dbgX7(dbgX7), .dbgX8(dbgX8), .dbgX9(dbgX9), .dbgX10(dbgX10)
  );

  function automatic logic [31:0] mkWord(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd,
                                         input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  // Vectors: add-immediate words, plus one with odd funct3/opcode (R8).
  localparam logic [31:0] PROG [15] = '{
    mkWord(12'd5,    5'd0,  3'd0, 5'd1,  7'h13), // x1 = 5
    mkWord(12'hFFF,  5'd0,  3'd0, 5'd2,  7'h13), // x2 = -1
    mkWord(12'h7FF,  5'd1,  3'd0, 5'd5,  7'h13), // x5 = 5 + 2047
    mkWord(12'h800,  5'd0,  3'd0, 5'd6,  7'h13), // x6 = -2048
    mkWord(12'hFFF,  5'd6,  3'd0, 5'd7,  7'h13), // x7 = -2049
    mkWord(12'd1,    5'd2,  3'd0, 5'd8,  7'h13), // x8 = -1 + 1 wraps to 0
    mkWord(12'd100,  5'd1,  3'd0, 5'd0,  7'h13), // write to x0 discarded
    mkWord(12'd0,    5'd0,  3'd0, 5'd9,  7'h13), // x9 = x0
    mkWord(12'hFFB,  5'd5,  3'd0, 5'd10, 7'h13), // x10 = x5 - 5
    mkWord(12'd3,    5'd1,  3'd0, 5'd1,  7'h13), // x1 = x1 + 3
    mkWord(12'd7,    5'd1,  3'd0, 5'd11, 7'h13), // hidden x11
    mkWord(12'd1,    5'd11, 3'd0, 5'd5,  7'h13), // x5 = x11 + 1
    mkWord(12'd9,    5'd0,  3'd7, 5'd6,  7'h33), // R8: still add
    mkWord(12'h123,  5'd10, 3'd0, 5'd2,  7'h13), // x2 = x10 + 0x123
    mkWord(12'h800,  5'd7,  3'd0, 5'd31, 7'h13)  // hidden x31
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input string tag);
    chk(pcOut,  expPc,     {tag, " R2 pc"});
    chk(dbgX1,  model[1],  {tag, " R10 x1"});
    chk(dbgX2,  model[2],  {tag, " R10 x2"});
    chk(dbgX5,  model[5],  {tag, " R7 x5"});
    chk(dbgX6,  model[6],  {tag, " R7 x6"});
    chk(dbgX7,  model[7],  {tag, " R5 x7"});
    chk(dbgX8,  model[8],  {tag, " R5 x8"});
    chk(dbgX9,  model[9],  {tag, " R6 x9"});
    chk(dbgX10, model[10], {tag, " R4 x10"});
    chk({memAddr | memWrData, 28'd0, memWrMask}, 64'd0 >> 32, {tag, " R9 mem"});
  endtask

  task automatic runWord(input logic [31:0] w);
    logic [31:0] sum;
    instrWord = w;
    sum = (w[19:15] == 5'd0 ? 32'd0 : model[w[19:15]]) + {{20{w[31]}}, w[31:20]};
    @(posedge clk);
    @(negedge clk);
    if (w[11:7] != 5'd0) model[w[11:7]] = sum; // R3 R5 R6
    expPc = expPc + 32'd4;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    expPc = 32'd0;
    chkAll("R1 reset");
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    for (int i = 0; i < 15; i++) begin
      runWord(PROG[i]);
      chkAll($sformatf("R5 vec%0d", i));
    end

    // R7: read hidden x31 back into a visible register.
    runWord(mkWord(12'd0, 5'd31, 3'd0, 5'd9, 7'h13));
    chkAll("R7 hidden x31");
    chk(dbgX9, 32'hFFFFF7FF - 32'd2048 + 32'd2048 - 32'd2048 + 32'd0 + 32'd0,
        "R4 x31 value");

    // R6: x0 written with a nonzero sum, then used as source.
    runWord(mkWord(12'h7FF, 5'd2, 3'd0, 5'd0, 7'h13));
    runWord(mkWord(12'd0, 5'd0, 3'd0, 5'd8, 7'h13));
    chk(dbgX8, 32'd0, "R6 x0 reads zero");

    // R1: mid-run reset clears state.
    doReset();
    runWord(mkWord(12'd42, 5'd0, 3'd0, 5'd10, 7'h13));
    chkAll("R1 after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule